// File: doc/BRIEF.md
# Overlapped-Bit Shift and Rotate Memory

This unit computes logical shifts, arithmetic right shifts and rotations without a multiplexer network. It has three small banks of physical bits. In each bank, every word-addressed register is a window onto the same bits at a different offset. Writing the operand into one register and reading it back through another gives the shifted word.

A probe sequencer steps through a fixed list of writes for the selected operation, one probe per clock. It ends with a single read into the result register and then raises a one-cycle done pulse.

The host raises `start_i` with an operand, a shift amount and an operation code while the unit is idle. It then waits for `done_o`. The result is held until the next accepted start.

Bank mappings, for a data bit j of register l:
- The linear bank has 2W bits, and the bit lands at j+l.
- The saturating bank has W bits, and the bit lands at min(j+l, W-1).
- The circular bank has W bits, and the bit lands at (j+l) mod W.

Top module: `ovl_shift_unit`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o` and `result_o` are all zero.
- R2: Op code 0 (logical right) returns `data_i >> amt_i` with zero fill. It uses 3 probes: zero to linear register W, operand to linear register 0, then a read of linear register amt. `done_o` rises at the 3rd rising edge after the edge that accepts start.
- R3: Op code 1 (logical left) returns `data_i << amt_i` with zero fill. It uses 3 probes: zero to linear register 0, operand to linear register amt, then a read of linear register 0. `done_o` rises at the 3rd edge after acceptance.
- R4: Op code 2 (arithmetic right) returns the operand shifted right by amt, with bit W-1 copied into the vacated positions. It uses 2 probes (write saturating register 0, read saturating register amt), so `done_o` rises at the 2nd edge.
- R5: Op code 3 (rotate right) returns the operand rotated right by amt. It uses 2 probes, so `done_o` rises at the 2nd edge.
- R6: Op code 4 (rotate left) returns the operand rotated left by amt. It uses 2 probes, so `done_o` rises at the 2nd edge.
- R7: Op codes 5, 6 and 7 are reserved. They return zero after a single probe, so `done_o` rises at the 1st edge.
- R8: A start raised while `busy_o` is high is ignored. The running operation completes with its own result and latency, and no further operation begins.
- R9: `done_o` is one cycle wide. `busy_o` goes high at the accepting edge and falls at the same edge where `done_o` rises. A start raised in the cycle where `done_o` is high is accepted.
- R10: While the unit is idle and no done pulse is present, `result_o` does not change, whatever the other inputs do.
- R11: A result does not depend on bank contents left behind by earlier operations.
- R12: The saturating bank is written only at register 0, so no write places two data bits on one physical bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 3 | Operation code (0 to 4 valid, 5 to 7 reserved) |
| amt_i | input | 3 | Shift or rotate amount |
| data_i | input | 8 | Operand word |
| busy_o | output | 1 | A probe sequence is running |
| done_o | output | 1 | One-cycle pulse: the result has just been loaded |
| result_o | output | 8 | Result of the last completed operation |

## Verification
Two events can coincide: a completion pulse and a new start request. The bench raises `start_i` in exactly the cycle where `done_o` is seen high. It then expects that request to be accepted at the next edge and to return its own correct result with its own latency. The pulse it arrived on must drop after one cycle. The opposite case, a start held high through a running sequence, is judged by the earlier operation's result and latency, and by `busy_o` staying low afterwards.

// File: rtl/ovl_shift_pkg.sv
package ovl_shift_pkg;

  typedef enum logic [2:0] {
    OP_SRL = 3'd0,
    OP_SLL = 3'd1,
    OP_SRA = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_LINE = 2'd1,
    BK_TAIL = 2'd2,
    BK_CIRC = 2'd3
  } bank_e;

  localparam int MAP_LINE = 0;
  localparam int MAP_TAIL = 1;
  localparam int MAP_CIRC = 2;

endpackage

// File: rtl/ovl_bank.sv
module ovl_bank
  import ovl_shift_pkg::*;
#(
  parameter int W   = 8,
  parameter int MAP = MAP_LINE,
  parameter int AW  = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  localparam int NP = (MAP == MAP_LINE) ? 2 * W : W;
  localparam int PW = $clog2(NP);

  logic [NP-1:0] bits_q, bits_d;

  // register bit j of register l -> physical bit
  function automatic logic [PW-1:0] phys(input int j, input int l);
    int s;
    s = j + l;
    if (MAP == MAP_TAIL) begin
      if (s > W - 1) s = W - 1;
    end else if (MAP == MAP_CIRC) begin
      s = s % W;
    end
    return PW'(s);
  endfunction

  always_comb begin
    bits_d = bits_q;
    if (we_i) begin
      for (int j = 0; j < W; j++) bits_d[phys(j, int'(waddr_i))] = wdata_i[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  for (genvar j = 0; j < W; j++) begin : g_rd
    assign rdata_o[j] = bits_q[phys(j, int'(raddr_i))];
  end

endmodule

// File: rtl/ovl_probe_seq.sv
module ovl_probe_seq
  import ovl_shift_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(W),
  parameter int AW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [SW-1:0] amt_i,
  input  logic [W-1:0]  data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o,
  output logic          line_we_o,
  output logic          tail_we_o,
  output logic          circ_we_o,
  output logic [AW-1:0] addr_o,
  output logic [W-1:0]  wdata_o,
  input  logic [W-1:0]  line_rd_i,
  input  logic [W-1:0]  tail_rd_i,
  input  logic [W-1:0]  circ_rd_i
);

  localparam logic [AW-1:0] ADDR_TOP = AW'(W);

  logic          busy_q, done_q;
  logic [1:0]    step_q;
  logic [2:0]    op_q;
  logic [AW-1:0] amt_q;
  logic [W-1:0]  opnd_q, res_q;

  logic          p_wr, p_opnd, p_last;
  bank_e         p_bank;
  logic [AW-1:0] p_addr;
  logic [W-1:0]  rd_mux;

  always_comb begin
    p_wr   = 1'b0;
    p_opnd = 1'b0;
    p_last = 1'b0;
    p_bank = BK_NONE;
    p_addr = '0;
    case (op_q)
      OP_SRL: begin
        p_bank = BK_LINE;
        case (step_q)
          2'd0:    begin p_wr = 1'b1; p_addr = ADDR_TOP; end
          2'd1:    begin p_wr = 1'b1; p_opnd = 1'b1; end
          default: begin p_last = 1'b1; p_addr = amt_q; end
        endcase
      end
      OP_SLL: begin
        p_bank = BK_LINE;
        case (step_q)
          2'd0:    p_wr = 1'b1;
          2'd1:    begin p_wr = 1'b1; p_opnd = 1'b1; p_addr = amt_q; end
          default: p_last = 1'b1;
        endcase
      end
      OP_SRA: begin
        p_bank = BK_TAIL;
        if (step_q == 2'd0) begin p_wr = 1'b1; p_opnd = 1'b1; end
        else                begin p_last = 1'b1; p_addr = amt_q; end
      end
      OP_ROR: begin
        p_bank = BK_CIRC;
        if (step_q == 2'd0) begin p_wr = 1'b1; p_opnd = 1'b1; end
        else                begin p_last = 1'b1; p_addr = amt_q; end
      end
      OP_ROL: begin
        p_bank = BK_CIRC;
        if (step_q == 2'd0) begin p_wr = 1'b1; p_opnd = 1'b1; p_addr = amt_q; end
        else                p_last = 1'b1;
      end
      default: p_last = 1'b1;  // reserved: single read of nothing
    endcase
  end

  always_comb begin
    case (p_bank)
      BK_LINE: rd_mux = line_rd_i;
      BK_TAIL: rd_mux = tail_rd_i;
      BK_CIRC: rd_mux = circ_rd_i;
      default: rd_mux = '0;
    endcase
  end

  assign line_we_o = busy_q && p_wr && (p_bank == BK_LINE);
  assign tail_we_o = busy_q && p_wr && (p_bank == BK_TAIL);
  assign circ_we_o = busy_q && p_wr && (p_bank == BK_CIRC);
  assign addr_o    = p_addr;
  assign wdata_o   = p_opnd ? opnd_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      op_q   <= '0;
      amt_q  <= '0;
      opnd_q <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          op_q   <= op_i;
          amt_q  <= AW'(amt_i);
          opnd_q <= data_i;
        end
      end else if (p_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= rd_mux;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

endmodule

// File: rtl/ovl_shift_unit.sv
module ovl_shift_unit
  import ovl_shift_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(W),
  parameter int AW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [SW-1:0] amt_i,
  input  logic [W-1:0]  data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);

  logic          line_we, tail_we, circ_we;
  logic [AW-1:0] probe_addr;
  logic [W-1:0]  probe_wdata;
  logic [W-1:0]  line_rd, tail_rd, circ_rd;

  ovl_probe_seq #(.W(W), .SW(SW), .AW(AW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (op_i),
    .amt_i     (amt_i),
    .data_i    (data_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .line_we_o (line_we),
    .tail_we_o (tail_we),
    .circ_we_o (circ_we),
    .addr_o    (probe_addr),
    .wdata_o   (probe_wdata),
    .line_rd_i (line_rd),
    .tail_rd_i (tail_rd),
    .circ_rd_i (circ_rd)
  );

  ovl_bank #(.W(W), .MAP(MAP_LINE), .AW(AW)) u_line (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (line_we),
    .waddr_i (probe_addr), .wdata_i (probe_wdata),
    .raddr_i (probe_addr), .rdata_o (line_rd)
  );

  ovl_bank #(.W(W), .MAP(MAP_TAIL), .AW(AW)) u_tail (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (tail_we),
    .waddr_i (probe_addr), .wdata_i (probe_wdata),
    .raddr_i (probe_addr), .rdata_o (tail_rd)
  );

  ovl_bank #(.W(W), .MAP(MAP_CIRC), .AW(AW)) u_circ (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (circ_we),
    .waddr_i (probe_addr), .wdata_i (probe_wdata),
    .raddr_i (probe_addr), .rdata_o (circ_rd)
  );

endmodule

// File: rtl/ovl_shift_chk.sv
module ovl_shift_chk #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          done_i,
  input logic [W-1:0]  result_i,
  input logic          tail_we_i,
  input logic [AW-1:0] addr_i
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);  // R9

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);  // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(busy_i) && !busy_i));  // R9

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !done_i) |-> $stable(result_i));  // R10

  AST_TAIL_WRITE_REG0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_we_i |-> (addr_i == '0));  // R12

endmodule

bind ovl_shift_unit ovl_shift_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .result_i  (result_o),
  .tail_we_i (tail_we),
  .addr_i    (probe_addr)
);

// File: tb/sim_ovl_shift_unit.sv
module sim_ovl_shift_unit;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [2:0] amt_i = '0;
  logic [7:0] data_i = '0;
  logic       busy_o, done_o;
  logic [7:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  ovl_shift_unit u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
    .op_i (op_i), .amt_i (amt_i), .data_i (data_i),
    .busy_o (busy_o), .done_o (done_o), .result_o (result_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input int op, input int d, input logic [7:0] x);
    logic [15:0] dbl;
    dbl = {x, x};
    case (op)
      0: return x >> d;
      1: return x << d;
      2: return 8'($signed(x) >>> d);
      3: return 8'(dbl >> d);
      4: begin dbl = dbl << d; return dbl[15:8]; end
      default: return 8'h00;
    endcase
  endfunction

  function automatic int probes(input int op);
    if (op <= 1) return 3;
    if (op <= 4) return 2;
    return 1;
  endfunction

  function automatic string rtag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // drive at negedge, accept at next posedge; returns edges to done, ends on the done negedge
  task automatic issue(input int op, input int d, input logic [7:0] x, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'(op); amt_i = 3'(d); data_i = x;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R9 busy after accept", int'(busy_o), 1);
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_all_ops;
    logic [7:0] pats [6] = '{8'hA5, 8'h5A, 8'h80, 8'h01, 8'hFF, 8'h6E};
    int lat;
    for (int op = 0; op < 5; op++)
      for (int d = 0; d < 8; d++)
        for (int p = 0; p < 6; p++) begin
          issue(op, d, pats[p], lat);
          chk({rtag(op), " result"}, int'(result_o), int'(model(op, d, pats[p])));
          chk({rtag(op), " latency"}, lat, probes(op));
          chk("R9 busy low at done", int'(busy_o), 0);
        end
  endtask

  task automatic t_reserved;
    int lat;
    for (int op = 5; op < 8; op++) begin
      issue(2, 3, 8'hC3, lat);
      issue(op, 5, 8'hFF, lat);
      chk("R7 result zero", int'(result_o), 0);
      chk("R7 latency", lat, 1);
    end
  endtask

  task automatic t_start_while_busy;
    int lat;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd0; amt_i = 3'd2; data_i = 8'hF0;
    @(negedge clk_i);
    op_i = 3'd1; amt_i = 3'd5; data_i = 8'h0F;  // start stays high while busy
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    chk("R8 result of first op", int'(result_o), 8'h3C);
    chk("R8 latency of first op", lat, 3);
    @(negedge clk_i);
    chk("R8 no second op started", int'(busy_o), 0);
    chk("R8 no extra done", int'(done_o), 0);
  endtask

  task automatic t_start_on_done;
    int lat;
    issue(3, 1, 8'h81, lat);
    chk("R5 result before chain", int'(result_o), 8'hC0);
    // new start in the same cycle done is high
    start_i = 1'b1; op_i = 3'd2; amt_i = 3'd4; data_i = 8'h90;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R9 done one cycle", int'(done_o), 0);
    chk("R9 start on done accepted", int'(busy_o), 1);
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    chk("R9 chained result", int'(result_o), 8'hF9);
    chk("R9 chained latency", lat, 2);
  endtask

  task automatic t_hold;
    int lat;
    logic [7:0] held;
    issue(4, 3, 8'h96, lat);
    held = result_o;
    chk("R6 result before hold", int'(held), 8'hB4);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      op_i = 3'(i); amt_i = 3'(7 - i); data_i = 8'(i * 37);
    end
    chk("R10 result held", int'(result_o), int'(held));
    chk("R10 no done while idle", int'(done_o), 0);
  endtask

  task automatic t_leftover;
    int lat;
    issue(1, 7, 8'hFF, lat);  // leaves ones in the upper linear bits
    issue(1, 0, 8'hFF, lat);
    issue(0, 7, 8'h80, lat);
    chk("R11 SRL after SLL residue", int'(result_o), 8'h01);
    issue(0, 3, 8'h00, lat);
    chk("R11 zero operand", int'(result_o), 8'h00);
    issue(1, 6, 8'hFF, lat);
    issue(1, 1, 8'h01, lat);
    chk("R11 SLL lower fill", int'(result_o), 8'h02);
    issue(4, 5, 8'h3C, lat);
    issue(2, 7, 8'h7F, lat);
    chk("R11 SRA positive max", int'(result_o), 8'h00);
  endtask

  initial begin
    t_reset();
    t_all_ops();
    t_reserved();
    t_start_while_busy();
    t_start_on_done();
    t_hold();
    t_leftover();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule